// File: doc/BRIEF.md
# I2C Master Bus-Sequence Engine

This block is the master side of a two-wire serial bus. Software controls it through a small register port. Each bus action has its own command bit: start, repeated start, stop, byte receive and acknowledge. A byte transmit is launched by writing the transmit register. Setting a command bit runs that one sequence. The bit reads back as 1 while the sequence runs and drops to 0 by itself when the sequence finishes.

The two bus lines are driven open-drain through active-low drive enables. A drive value of 0 pulls the line low and 1 releases it. The data line is read back through `sda_in`. Bit timing comes from a programmable half-bit divider, and every step of every sequence lasts one half-bit.

The controller is a state machine with seven states: IDLE, START, RSTART, STOP, TX, RX and ACK. The only transitions are:
- IDLE to one of the six sequence states, when a command is accepted while idle.
- Any sequence state back to IDLE, on the half-bit tick that closes its last step.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset, both drive enables are 1 (lines released), and the control and status registers read 0. The divider register reads its reset value.
- R2: Writing control (address 0) with bit 0 set runs a start. SDA goes low while SCL is high for one half-bit, then SCL goes low. Bit 0 reads 1 while the start runs and 0 afterwards.
- R3: Control bit 2 runs a stop. SCL is low, then SCL is released while SDA is held low, then SDA is released while SCL is high. Both lines end released.
- R4: Control bit 1 runs a repeated start. It releases SDA, then SCL, then pulls SDA low while SCL is high, then pulls SCL low. It never forms a stop on the way.
- R5: Writing the transmit register (address 2) while idle shifts out 8 bits, MSB first, on 9 SCL pulses. The ninth pulse is for the slave's acknowledge. SDA only changes while SCL is low.
- R6: The line value seen during the ninth transmit pulse lands in status bit 1 (0 = ACK, 1 = NACK). The status register is at address 1.
- R7: Control bit 3 receives one byte. The engine gives 8 SCL pulses and takes SDA MSB first while SCL is high. When the 8 bits are in, the byte appears at address 3 and status bit 2 (receive full) is set. Control bit 3 clears before any acknowledge is sent.
- R8: Control bit 4 sends one acknowledge pulse. During the pulse the master drives control bit 5: 0 pulls SDA low (ACK) and 1 leaves it released (NACK). Bit 4 clears at the end of the pulse.
- R9: An acknowledge command is accepted only when the most recently completed sequence was a receive. Otherwise it is ignored: no SCL pulse, and bit 4 reads 0.
- R10: While a sequence runs, a control write with any of bits 4..0 set, or a transmit write, is ignored. Such a write sets status bit 3 (collision). Writing the status address clears the collision bit.
- R11: When several command bits are written together while idle, only the lowest-numbered one runs. The order is start, then repeated start, then stop, then receive, then acknowledge.
- R12: Each sequence step lasts max(D,1)+1 clock cycles, where D is the divider register at address 4. A start therefore takes 2 steps, a stop 3 and a repeated start 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| sda_in | input | 1 | Sampled level of the data line |
| scl_drv_n | output | 1 | Clock line drive enable, 0 pulls low |
| sda_drv_n | output | 1 | Data line drive enable, 0 pulls low |

## Verification
The failures that matter most are a sequence state held one step too long or left too early, and a step counter that is off by one. Either one shows at the ports within one half-bit. It appears as a missing or extra SCL pulse, a start or stop condition where none belongs, or a busy flag whose length no longer matches the divider arithmetic. A shift register out of step shows as a wrong byte on the first transfer. It also moves the acknowledge sample to a data bit, so the status bit flips on the same transfer. Collision and priority faults show on the very next write: a sequence that should not run leaves the lines in the wrong final levels.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_RSTART,
        SQ_STOP,
        SQ_TX,
        SQ_RX,
        SQ_ACK
    } seq_t;

    // register addresses
    localparam int A_CTRL = 0;
    localparam int A_STAT = 1;
    localparam int A_TXD  = 2;
    localparam int A_RXD  = 3;
    localparam int A_DIV  = 4;

    // control bits (index is also the command priority)
    localparam int B_START  = 0;
    localparam int B_RSTART = 1;
    localparam int B_STOP   = 2;
    localparam int B_RXGO   = 3;
    localparam int B_ACKGO  = 4;
    localparam int B_ACKVAL = 5;

    // status bits
    localparam int S_BUSY  = 0;
    localparam int S_ACKIN = 1;
    localparam int S_RXFUL = 2;
    localparam int S_WCOL  = 3;

endpackage

// File: rtl/i2c_halfbit_timer.sv
module i2c_halfbit_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    // a divider of zero is treated as one so every step spans two cycles
    assign lim  = (div == '0) ? W'(1) : div;
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    a_r12_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], in_bit};
    end
endmodule

// File: rtl/i2c_seq_master.sv
module i2c_seq_master
    import i2c_seq_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 3,
    parameter int DIV_W    = 8,
    parameter int DIV_INIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          sda_in,
    output logic          scl_drv_n,
    output logic          sda_drv_n
);
    localparam int STEP_W      = $clog2(2*DW + 3);
    localparam int TX_DATA_END = 2*DW;      // steps below this carry data bits
    localparam int TX_ACK_STEP = 2*DW + 1;  // SCL-high step of the ninth pulse
    localparam int TX_LAST     = 2*DW + 2;
    localparam int RX_LAST     = 2*DW;

    seq_t              state, cmd_pick;
    logic [STEP_W-1:0] step, last_step;
    logic              busy, tick, seq_done;
    logic              ctrl_wr, tx_wr, stat_wr, div_wr, go_any, clash;
    logic [DIV_W-1:0]  div_q;
    logic              ack_val, ack_in, rx_full, wcol, last_rx;
    logic [DW-1:0]     sh_q, rxd_q;
    logic              sh_load, sh_shift, sh_bit;
    logic              scl_nx, sda_nx, scl_q, sda_q;

    assign busy    = (state != SQ_IDLE);
    assign ctrl_wr = wr_en && (wr_addr == AW'(A_CTRL));
    assign stat_wr = wr_en && (wr_addr == AW'(A_STAT));
    assign tx_wr   = wr_en && (wr_addr == AW'(A_TXD));
    assign div_wr  = wr_en && (wr_addr == AW'(A_DIV));
    assign go_any  = |wr_data[B_ACKGO:B_START];
    assign clash   = busy && ((ctrl_wr && go_any) || tx_wr);

    i2c_halfbit_timer #(.W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (div_q),
        .tick (tick)
    );

    assign sh_load  = !busy && tx_wr;
    assign sh_bit   = (state == SQ_RX) ? sda_in : 1'b1;
    assign sh_shift = tick && step[0] &&
                      (((state == SQ_TX) && (step < STEP_W'(TX_DATA_END))) || (state == SQ_RX));

    i2c_byte_shift #(.W(DW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(wr_data),
        .shift   (sh_shift),
        .in_bit  (sh_bit),
        .q       (sh_q)
    );

    // command selection: lowest bit wins; acknowledge only after a receive
    always_comb begin
        if (wr_data[B_START])                   cmd_pick = SQ_START;
        else if (wr_data[B_RSTART])             cmd_pick = SQ_RSTART;
        else if (wr_data[B_STOP])               cmd_pick = SQ_STOP;
        else if (wr_data[B_RXGO])               cmd_pick = SQ_RX;
        else if (wr_data[B_ACKGO] && last_rx)   cmd_pick = SQ_ACK;
        else                                    cmd_pick = SQ_IDLE;
    end

    always_comb begin
        unique case (state)
            SQ_START:  last_step = STEP_W'(1);
            SQ_RSTART: last_step = STEP_W'(3);
            SQ_STOP:   last_step = STEP_W'(2);
            SQ_TX:     last_step = STEP_W'(TX_LAST);
            SQ_RX:     last_step = STEP_W'(RX_LAST);
            SQ_ACK:    last_step = STEP_W'(2);
            default:   last_step = '0;
        endcase
    end

    assign seq_done = tick && (step == last_step);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            step  <= '0;
        end else if (!busy) begin
            step <= '0;
            if (tx_wr)
                state <= SQ_TX;
            else if (ctrl_wr)
                state <= cmd_pick;
        end else if (tick) begin
            if (seq_done) begin
                state <= SQ_IDLE;
                step  <= '0;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    // software-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(DIV_INIT);
            ack_val <= 1'b0;
            ack_in  <= 1'b0;
            rx_full <= 1'b0;
            wcol    <= 1'b0;
            last_rx <= 1'b0;
            rxd_q   <= '0;
        end else begin
            if (ctrl_wr && !busy)
                ack_val <= wr_data[B_ACKVAL];
            if (div_wr && !busy)
                div_q <= DIV_W'(wr_data);
            if (clash)
                wcol <= 1'b1;
            else if (stat_wr)
                wcol <= 1'b0;
            if (!busy && (tx_wr || (ctrl_wr && cmd_pick == SQ_RX)))
                rx_full <= 1'b0;
            if (tick && (state == SQ_TX) && (step == STEP_W'(TX_ACK_STEP)))
                ack_in <= sda_in;
            if (seq_done) begin
                last_rx <= (state == SQ_RX);
                if (state == SQ_RX) begin
                    rxd_q   <= sh_q;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    // line levels per state and step
    always_comb begin
        scl_nx = scl_q;
        sda_nx = sda_q;
        unique case (state)
            SQ_IDLE: ;
            SQ_START: begin
                scl_nx = (step == '0);
                sda_nx = 1'b0;
            end
            SQ_RSTART: begin
                scl_nx = (step == STEP_W'(1)) || (step == STEP_W'(2));
                sda_nx = (step < STEP_W'(2));
            end
            SQ_STOP: begin
                scl_nx = (step != '0);
                sda_nx = (step == STEP_W'(2));
            end
            SQ_TX: begin
                scl_nx = step[0];
                sda_nx = (step < STEP_W'(TX_DATA_END)) ? sh_q[DW-1] : 1'b1;
            end
            SQ_RX: begin
                scl_nx = step[0];
                sda_nx = 1'b1;
            end
            SQ_ACK: begin
                scl_nx = (step == STEP_W'(1));
                sda_nx = ack_val;
            end
            default: ;
        endcase
    end

    // output register: SDA waits one cycle whenever SCL is being pulled low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_nx;
            sda_q <= (scl_q && !scl_nx) ? sda_q : sda_nx;
        end
    end

    assign scl_drv_n = scl_q;
    assign sda_drv_n = sda_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(A_CTRL): begin
                rd_data[B_START]  = (state == SQ_START);
                rd_data[B_RSTART] = (state == SQ_RSTART);
                rd_data[B_STOP]   = (state == SQ_STOP);
                rd_data[B_RXGO]   = (state == SQ_RX);
                rd_data[B_ACKGO]  = (state == SQ_ACK);
                rd_data[B_ACKVAL] = ack_val;
            end
            AW'(A_STAT): begin
                rd_data[S_BUSY]  = busy;
                rd_data[S_ACKIN] = ack_in;
                rd_data[S_RXFUL] = rx_full;
                rd_data[S_WCOL]  = wcol;
            end
            AW'(A_RXD): rd_data = rxd_q;
            AW'(A_DIV): rd_data = DW'(div_q);
            default: ;
        endcase
    end

    a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(state) == SQ_TX) || ($past(state) == SQ_RX) || ($past(state) == SQ_ACK))
          && (sda_q != $past(sda_q))) |-> (!scl_q && !$past(scl_q)));

    a_r2_fall_only_in_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_q) && scl_q && $past(scl_q)) |->
        (($past(state) == SQ_START) || ($past(state) == SQ_RSTART)));

    a_r3_rise_only_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_q) && scl_q && $past(scl_q)) |-> ($past(state) == SQ_STOP));

    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && clash) |=> ((state == $past(state)) || (state == SQ_IDLE)));

endmodule

// File: tb/i2c_seq_master_test.sv
`timescale 1ns/1ps
module i2c_seq_master_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [2:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       sda_in, scl_drv_n, sda_drv_n;
    logic       slave_sda = 1'b1;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    assign sda_in = sda_drv_n & slave_sda;

    i2c_seq_master #(.DIV_INIT(4)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sda_in   (sda_in),
        .scl_drv_n(scl_drv_n),
        .sda_drv_n(sda_drv_n)
    );

    // slave model, evaluated on the falling clock edge
    int         arm_id = 0;
    int         seen_id = 0;
    bit         mode_rx = 1'b0;
    logic [7:0] sl_byte = 8'h00;
    logic       sl_ack = 1'b0;
    int         rises = 0;
    int         starts = 0;
    int         stops = 0;
    logic [8:0] cap = '0;
    logic       p_scl = 1'b1;
    logic       p_sda = 1'b1;

    always @(negedge clk) begin
        logic bs;
        bs = sda_drv_n & slave_sda;
        if (arm_id != seen_id) begin
            seen_id   = arm_id;
            rises     = 0;
            slave_sda = mode_rx ? sl_byte[7] : 1'b1;
        end else begin
            if (!p_scl && scl_drv_n) begin
                rises = rises + 1;
                cap   = {cap[7:0], bs};
            end
            if (p_scl && !scl_drv_n) begin
                if (mode_rx)
                    slave_sda = (rises < 8) ? sl_byte[7-rises] : 1'b1;
                else
                    slave_sda = (rises == 8) ? sl_ack : 1'b1;
            end
            if (p_scl && scl_drv_n && p_sda && !bs)
                starts = starts + 1;
            if (p_scl && scl_drv_n && !p_sda && bs)
                stops = stops + 1;
        end
        p_scl = scl_drv_n;
        p_sda = sda_drv_n & slave_sda;
    end

    // {receive?, byte, flag}: flag = slave ack for transmit, master ack value for receive
    localparam logic [9:0] VECS [6] = '{
        {1'b0, 8'hA5, 1'b0},
        {1'b1, 8'h3C, 1'b0},
        {1'b1, 8'h96, 1'b0},
        {1'b0, 8'h5A, 1'b1},
        {1'b1, 8'hF0, 1'b1},
        {1'b0, 8'h81, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] s;
        n = 0;
        peek(3'd1, s);
        while (s[0] && n < 400) begin
            n++;
            @(negedge clk);
            peek(3'd1, s);
        end
    endtask

    task automatic arm(input bit rx, input logic [7:0] b, input logic a);
        mode_rx = rx;
        sl_byte = b;
        sl_ack  = a;
        arm_id  = arm_id + 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n, s0, p0, r0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 scl", int'(scl_drv_n), 1);
        chk("R1 sda", int'(sda_drv_n), 1);
        peek(3'd0, v); chk("R1 ctrl", int'(v), 0);
        peek(3'd1, v); chk("R1 stat", int'(v), 0);
        peek(3'd4, v); chk("R1 div", int'(v), 4);

        // R12 divider zero behaves as one: start 2 steps of 2 cycles
        wr(3'd4, 8'd0);
        s0 = starts;
        wr(3'd0, 8'h01);
        peek(3'd0, v); chk("R2 start bit busy", int'(v), 1);
        wait_idle(n);  chk("R12 start len div0", n, 4);
        chk("R2 start seen", starts - s0, 1);
        chk("R2 scl low", int'(scl_drv_n), 0);
        chk("R2 sda low", int'(sda_drv_n), 0);
        peek(3'd0, v); chk("R2 start bit clear", int'(v), 0);

        p0 = stops;
        wr(3'd0, 8'h04);
        wait_idle(n);  chk("R12 stop len div0", n, 6);
        chk("R3 stop seen", stops - p0, 1);
        chk("R3 lines released", int'({scl_drv_n, sda_drv_n}), 3);

        wr(3'd4, 8'd3);
        wr(3'd0, 8'h01);
        wait_idle(n);  chk("R12 start len div3", n, 8);

        // vector table
        for (int i = 0; i < 6; i++) begin
            logic [9:0] vec;
            vec = VECS[i];
            if (!vec[9]) begin
                arm(1'b0, vec[8:1], vec[0]);
                wr(3'd2, vec[8:1]);
                wait_idle(n);
                chk("R5 tx byte", int'(cap[8:1]), int'(vec[8:1]));
                chk("R5 nine pulses", rises, 9);
                peek(3'd1, v);
                chk("R6 ack status", int'(v[1]), int'(vec[0]));
            end else begin
                arm(1'b1, vec[8:1], 1'b0);
                wr(3'd0, 8'h08);
                peek(3'd0, v); chk("R7 rx bit busy", int'(v[3]), 1);
                wait_idle(n);
                chk("R7 eight pulses", rises, 8);
                peek(3'd3, v); chk("R7 rx byte", int'(v), int'(vec[8:1]));
                peek(3'd1, v); chk("R7 rx full", int'(v[2]), 1);
                peek(3'd0, v); chk("R7 rx bit clear", int'(v[4:0]), 0);
                wr(3'd0, vec[0] ? 8'h30 : 8'h10);
                wait_idle(n);
                chk("R8 ack pulse", rises, 9);
                chk("R8 ack level", int'(cap[0]), int'(vec[0]));
                peek(3'd0, v); chk("R8 ack bit clear", int'(v[4:0]), 0);
            end
        end

        // R9 acknowledge after a transmit is ignored
        r0 = rises;
        wr(3'd0, 8'h10);
        peek(3'd1, v); chk("R9 not busy", int'(v[0]), 0);
        peek(3'd0, v); chk("R9 ack bit", int'(v[4]), 0);
        repeat (12) @(negedge clk);
        chk("R9 no pulse", rises - r0, 0);

        // R4 repeated start
        s0 = starts; p0 = stops;
        wr(3'd0, 8'h02);
        wait_idle(n);  chk("R4 rstart len", n, 16);
        chk("R4 start formed", starts - s0, 1);
        chk("R4 no stop", stops - p0, 0);
        chk("R4 lines low", int'({scl_drv_n, sda_drv_n}), 0);

        // R3 stop after transfers
        p0 = stops;
        wr(3'd0, 8'h04);
        wait_idle(n);  chk("R3 stop len", n, 12);
        chk("R3 stop formed", stops - p0, 1);
        chk("R3 released", int'({scl_drv_n, sda_drv_n}), 3);

        // R10 command during a running stop
        s0 = starts; p0 = stops;
        wr(3'd0, 8'h04);
        wr(3'd0, 8'h01);
        peek(3'd1, v); chk("R10 collision set", int'(v[3]), 1);
        wait_idle(n);
        chk("R10 start ignored", starts - s0, 0);
        chk("R10 stop ran", stops - p0, 1);
        chk("R10 released", int'({scl_drv_n, sda_drv_n}), 3);
        wr(3'd1, 8'h00);
        peek(3'd1, v); chk("R10 collision clear", int'(v[3]), 0);

        // R10 transmit during a running start
        r0 = rises;
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h55);
        peek(3'd1, v); chk("R10 tx collision", int'(v[3]), 1);
        wait_idle(n);
        repeat (8) @(negedge clk);
        chk("R10 tx ignored", rises - r0, 0);
        wr(3'd1, 8'h00);

        // R11 start and stop together: start wins
        wr(3'd0, 8'h04);
        wait_idle(n);
        s0 = starts; p0 = stops;
        wr(3'd0, 8'h05);
        wait_idle(n);  chk("R11 start length", n, 8);
        chk("R11 start ran", starts - s0, 1);
        chk("R11 stop skipped", stops - p0, 0);
        chk("R11 lines low", int'({scl_drv_n, sda_drv_n}), 0);

        wr(3'd0, 8'h04);
        wait_idle(n);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule